// File: doc/BRIEF.md
# Quad DAC Serial Register Interface

This block is the digital front end of a four-channel, 12-bit converter. A host sends 16-bit frames over a three-wire serial link: an active-low frame line, a serial clock and a data input. It can read register values back on a serial data output. The serial lines are asynchronous to the block. They are brought into a fast system clock through two-flop synchronizers and then edge-detected. For this reason each serial clock level must last at least three system clock cycles.

Each channel has two registers. The input register receives writes from the serial link. The DAC register holds the code presented to the analog side. A per-channel pending flag records that an input register holds a value not yet moved to the DAC register. A falling edge on the load strobe moves every pending channel together. If the load strobe is held low, writes pass straight through to the DAC register. A falling edge on the clear input zeroes both register sets. While clear stays low, load strobes have no effect.

A frame is sent MSB first. Bit 15 selects the operation: 1 is a read and 0 is a write. Bits 14:12 give the channel address, where codes 0 to 3 select channels A to D. Bits 11:0 carry the data. The four DAC register values are presented on one flat output bus, with channel A in bits 11:0, B in 23:12, C in 35:24 and D in 47:36.

Top module: `qdac_serial_if`

## Requirements
- R1: A falling edge of `sync_n` starts a frame. Each following falling edge of `sclk` captures one `sdi` bit, MSB first. Bit 15 is the read flag, bits 14:12 are the address and bits 11:0 are the data.
- R2: A frame acts only on the 16th falling `sclk` edge. After 15 edges no register has changed. Further edges in the same frame are ignored.
- R3: If `sync_n` rises before the 16th falling edge, the frame is discarded and no register changes.
- R4: A write to address 4 to 7 changes no register. A read of address 4 to 7 returns an all-zero word.
- R5: A completed write while `ldac_n` is high updates only the input register of the addressed channel and marks that channel pending. The DAC register is left unchanged.
- R6: A falling edge of `ldac_n` while `clr_n` is high copies every pending input register into its DAC register in the same cycle and clears all pending marks. Channels that are not pending keep their DAC values.
- R7: A write that completes while `ldac_n` is low and `clr_n` is high updates both the input register and the DAC register of that channel.
- R8: A falling edge of `clr_n` sets all input registers and all DAC registers to 0x000 and clears every pending mark.
- R9: While `clr_n` is low, `ldac_n` edges have no effect and writes do not pass through to DAC registers. Writes still update input registers and set pending marks.
- R10: A read frame loads the word {4'b0, DAC register} of the addressed channel into the readback shifter. During the next frame, `sdo` presents this word MSB first. The first bit appears after `sync_n` falls, and `sdo` advances on each rising `sclk` edge that follows a falling edge, so the host samples every bit on a falling edge.
- R11: `sdo` is 0 whenever `sync_n` is high.
- R12: After reset, every DAC register reads 0 and `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idle high |
| sync_n | input | 1 | Active-low frame line |
| sdi | input | 1 | Serial data in |
| ldac_n | input | 1 | Active-low load strobe |
| clr_n | input | 1 | Active-low clear, acts on its falling edge |
| sdo | output | 1 | Serial readback data |
| dac_word | output | 48 | DAC register values; channel A in the lowest 12 bits |

## Verification
A wrong frame bit count or a missed abort appears on `dac_word` within a few system cycles of the 16th serial clock edge: a channel changes when it should not, or fails to change. A pending mark left in the wrong state stays hidden until the next load strobe. At that point a channel moves, or fails to move, in the cycle after the synchronized strobe edge. A corrupted readback shifter shows on `sdo` only during the frame after the read, one bit per serial clock.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    localparam int CH_N    = 4;
    localparam int DATA_W  = 12;
    localparam int FRAME_W = 16;
    localparam int ADDR_W  = 3;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int          W       = 5,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d    = q;
        d.s1 = din;
        d.s2 = q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{s1: RST_VAL, s2: RST_VAL};
        else        q <= d;
    end

    assign dout = q.s2;
endmodule

// File: rtl/qdac_frame.sv
module qdac_frame #(
    parameter int FRAME_W = 16,
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sync_s,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              sdo_o
);
    localparam int             CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

    typedef struct packed {
        logic               active;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] shreg;
        logic [FRAME_W-1:0] tx;
        logic               sclk_prev;
        logic               sync_prev;
    } frame_t;

    frame_t d, q;
    logic   sclk_fall, sclk_rise, sync_fall, done;
    logic [FRAME_W-1:0] word_d;

    assign sclk_fall = q.sclk_prev & ~sclk_s;
    assign sclk_rise = ~q.sclk_prev & sclk_s;
    assign sync_fall = q.sync_prev & ~sync_s;
    assign word_d    = {q.shreg[FRAME_W-2:0], sdi_s};

    always_comb begin
        d           = q;
        d.sclk_prev = sclk_s;
        d.sync_prev = sync_s;
        done        = 1'b0;
        if (sync_s) begin
            d.active = 1'b0;
        end else if (sync_fall) begin
            d.active = 1'b1;
            d.cnt    = '0;
        end else if (q.active) begin
            if (sclk_fall && q.cnt < FULL) begin
                d.shreg = word_d;
                d.cnt   = q.cnt + CNT_W'(1);
                done    = (q.cnt == LAST);
            end
            if (sclk_rise && q.cnt != '0 && q.cnt < FULL) begin
                d.tx = {q.tx[FRAME_W-2:0], 1'b0};
            end
            if (done && word_d[FRAME_W-1]) begin
                d.tx = FRAME_W'(rd_data);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{active: 1'b0, cnt: '0, shreg: '0, tx: '0,
                           sclk_prev: 1'b1, sync_prev: 1'b1};
        else        q <= d;
    end

    assign wr_o   = done & ~word_d[FRAME_W-1];
    assign addr_o = word_d[FRAME_W-2 -: ADDR_W];
    assign data_o = word_d[DATA_W-1:0];
    assign sdo_o  = q.active & q.tx[FRAME_W-1];

    // R2: a completed frame leaves the counter saturated
    a_r2_full_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (q.cnt == FULL));
    // R2: the bit counter never passes the frame length
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= FULL);
    // R3: a high frame line closes any frame in progress
    a_r3_close_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
        sync_s |=> !q.active);
    // R10: the readback shifter holds still between frames
    a_r10_tx_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sync_s |=> $stable(q.tx));
endmodule

// File: rtl/qdac_regs.sv
module qdac_regs #(
    parameter int CH_N   = 4,
    parameter int DATA_W = 12,
    parameter int ADDR_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ldac_s,
    input  logic                   clr_s,
    input  logic                   wr_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [DATA_W-1:0]      data_i,
    output logic [DATA_W-1:0]      rd_data_o,
    output logic [CH_N*DATA_W-1:0] dac_o
);
    localparam int CH_W = (CH_N > 1) ? $clog2(CH_N) : 1;

    typedef struct packed {
        logic [CH_N-1:0][DATA_W-1:0] inr;
        logic [CH_N-1:0][DATA_W-1:0] dac;
        logic [CH_N-1:0]             pend;
        logic                        ldac_prev;
        logic                        clr_prev;
    } regs_t;

    regs_t d, q;
    logic  ldac_fall, clr_fall, addr_ok;
    logic [CH_W-1:0] ch;

    assign ldac_fall = q.ldac_prev & ~ldac_s;
    assign clr_fall  = q.clr_prev & ~clr_s;
    assign addr_ok   = ({1'b0, addr_i} < (ADDR_W + 1)'(CH_N));
    assign ch        = addr_i[CH_W-1:0];

    always_comb begin
        d           = q;
        d.ldac_prev = ldac_s;
        d.clr_prev  = clr_s;
        if (clr_fall) begin
            d.inr  = '0;
            d.dac  = '0;
            d.pend = '0;
        end else begin
            if (ldac_fall && clr_s) begin
                for (int i = 0; i < CH_N; i++) begin
                    if (q.pend[i]) d.dac[i] = q.inr[i];
                end
                d.pend = '0;
            end
            if (wr_i && addr_ok) begin
                d.inr[ch] = data_i;
                if (!ldac_s && clr_s) begin
                    d.dac[ch]  = data_i;
                    d.pend[ch] = 1'b0;
                end else begin
                    d.pend[ch] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{inr: '0, dac: '0, pend: '0, ldac_prev: 1'b1, clr_prev: 1'b1};
        else        q <= d;
    end

    always_comb begin
        rd_data_o = '0;
        if (addr_ok) rd_data_o = q.dac[ch];
    end

    assign dac_o = q.dac;

    // R8: a clear edge empties both register sets
    a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fall |=> (q.dac == '0 && q.inr == '0 && q.pend == '0));
    // R9: DAC registers stay put while clear is held
    a_r9_hold_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.clr_prev && !clr_s) |=> $stable(q.dac));
    // R6: a load strobe leaves nothing pending
    a_r6_pend_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (ldac_fall && clr_s) |=> (q.pend == '0));
    // R7: a write with the strobe held low reaches the DAC register
    a_r7_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_ok && !ldac_s && clr_s) |=> (q.dac[$past(ch)] == $past(data_i)));
endmodule

// File: rtl/qdac_serial_if.sv
module qdac_serial_if
    import qdac_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sclk,
    input  logic                   sync_n,
    input  logic                   sdi,
    input  logic                   ldac_n,
    input  logic                   clr_n,
    output logic                   sdo,
    output logic [CH_N*DATA_W-1:0] dac_word
);
    logic [4:0]        raw, synced;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata, rdata;

    assign raw = {clr_n, ldac_n, sync_n, sclk, sdi};

    qdac_sync #(.W(5), .RST_VAL(5'b11110)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw),
        .dout (synced)
    );

    qdac_frame #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (synced[1]),
        .sync_s (synced[2]),
        .sdi_s  (synced[0]),
        .rd_data(rdata),
        .wr_o   (wr),
        .addr_o (addr),
        .data_o (wdata),
        .sdo_o  (sdo)
    );

    qdac_regs #(.CH_N(CH_N), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ldac_s   (synced[3]),
        .clr_s    (synced[4]),
        .wr_i     (wr),
        .addr_i   (addr),
        .data_i   (wdata),
        .rd_data_o(rdata),
        .dac_o    (dac_word)
    );
endmodule

// File: tb/qdac_serial_if_bench.sv
module qdac_serial_if_bench;
    localparam time HALF = 40ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1, sync_n = 1'b1, sdi = 1'b0, ldac_n = 1'b1, clr_n = 1'b1;
    logic        sdo;
    logic [47:0] dac_word;

    int          n_checks = 0;
    int          n_errors = 0;
    logic [11:0] exp_dac [4];
    logic [15:0] rx_word;

    qdac_serial_if u_qdac_serial_if (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .sdi(sdi),
        .ldac_n(ldac_n), .clr_n(clr_n), .sdo(sdo), .dac_word(dac_word)
    );

    always #2ns clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int c = 0; c < 4; c++) check(req, 32'(dac_word[c*12 +: 12]), 32'(exp_dac[c]));
    endtask

    task automatic frame_begin();
        sync_n = 1'b0; #HALF;
    endtask

    task automatic frame_end();
        sync_n = 1'b1; #(2*HALF);
    endtask

    // shifts bits hi..lo of w; records sdo just before each falling edge
    task automatic send_range(input logic [15:0] w, input int hi, input int lo);
        for (int i = hi; i >= lo; i--) begin
            sdi = w[i]; #HALF;
            rx_word[i] = sdo;
            sclk = 1'b0; #HALF;
            sclk = 1'b1;
        end
        #HALF;
    endtask

    task automatic xfer(input logic [15:0] w);
        frame_begin(); send_range(w, 15, 0); frame_end();
    endtask

    function automatic logic [15:0] wr_word(input int a, input logic [11:0] v);
        return {1'b0, 3'(a), v};
    endfunction

    task automatic pulse_ldac();
        ldac_n = 1'b0; #(2*HALF); ldac_n = 1'b1; #(2*HALF);
    endtask

    task automatic t_reset();
        for (int c = 0; c < 4; c++) exp_dac[c] = '0;
        check_all("R12 reset dac");
        check("R12 reset sdo", 32'(sdo), 0);
    endtask

    task automatic t_buffered();
        xfer(wr_word(0, 12'hABC));
        xfer(wr_word(1, 12'h123));
        check_all("R5 input only while ldac high");
        pulse_ldac();
        exp_dac[0] = 12'hABC; exp_dac[1] = 12'h123;
        check_all("R6 R1 load strobe moves pending");
    endtask

    task automatic t_partial();
        ldac_n = 1'b0; #(2*HALF);
        frame_begin(); send_range(wr_word(2, 12'h5A5), 15, 1);
        check_all("R2 no change after 15 edges");
        send_range(wr_word(2, 12'h5A5), 0, 0);
        exp_dac[2] = 12'h5A5;
        check_all("R2 R7 change on 16th edge");
        send_range(16'h0FFF, 15, 12);
        frame_end();
        check_all("R2 extra edges ignored");
        frame_begin(); send_range(wr_word(2, 12'h111), 15, 6); frame_end();
        check_all("R3 aborted frame discarded");
        xfer(wr_word(3, 12'hFFF));
        exp_dac[3] = 12'hFFF;
        check_all("R7 pass through on channel D");
        xfer(wr_word(5, 12'h777));
        check_all("R4 write to address 5 ignored");
        ldac_n = 1'b1; #(2*HALF);
    endtask

    task automatic t_readback();
        xfer({1'b1, 3'd1, 12'h000});
        check("R11 sdo low between frames", 32'(sdo), 0);
        xfer(wr_word(7, 12'h3C3));
        check("R10 readback of channel B", 32'(rx_word), 32'h0123);
        check_all("R4 write to address 7 ignored");
        xfer({1'b1, 3'd0, 12'h000});
        xfer({1'b1, 3'd6, 12'h000});
        check("R10 readback of channel A", 32'(rx_word), 32'h0ABC);
        xfer(wr_word(4, 12'h000));
        check("R4 read of address 6 is zero", 32'(rx_word), 0);
        check("R11 sdo low after frames", 32'(sdo), 0);
    endtask

    task automatic t_clear();
        xfer(wr_word(2, 12'h999));
        clr_n = 1'b0; #(2*HALF);
        for (int c = 0; c < 4; c++) exp_dac[c] = '0;
        check_all("R8 clear zeroes dac");
        xfer(wr_word(0, 12'h246));
        pulse_ldac();
        check_all("R9 load strobe ignored in clear");
        ldac_n = 1'b0; #(2*HALF);
        xfer(wr_word(1, 12'h135));
        check_all("R9 no pass through in clear");
        ldac_n = 1'b1; #(2*HALF);
        clr_n = 1'b1; #(2*HALF);
        check_all("R9 clear release alone changes nothing");
        pulse_ldac();
        exp_dac[0] = 12'h246; exp_dac[1] = 12'h135;
        check_all("R8 R6 pending from clear window, C input zeroed");
    endtask

    initial begin
        #(2_000_000ns);
        n_errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        #21ns; rst_n = 1'b1; #(2*HALF);
        t_reset();
        t_buffered();
        t_partial();
        t_readback();
        t_clear();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule